// File: doc/BRIEF.md
# Oversampling Serial Receiver With Three-Sample Voting

This block receives asynchronous serial characters on a single line. It is paced by a one-cycle sample strobe that runs at sixteen times the bit rate. While idle it waits for a low sample, which it treats as the possible leading edge of a start bit. It then takes three samples near the middle of every bit period and decides each bit by a two-out-of-three vote. Data bits arrive least significant first. A mode input selects characters of eight or nine data bits.

When the stop bit has been voted on, the character is copied into a holding register and a ready flag rises. This happens even when the stop bit was bad, in which case a framing error flag travels with the character. The processor side has a read strobe and status outputs. If a character completes while the previous one is still unread, the new one is dropped. A pending overrun is then recorded, and it becomes visible only when the holding register is read. An enable input can stop the receiver at any point without losing the character already held.

Top module: `uart_rx_vote`

## Requirements
- R1: In idle, a low `rx_in` on a `smp_tick` cycle is sample 1 of a start bit. Samples 8, 9 and 10 are then taken. If at least two of them are high, the start is dropped, nothing is delivered, and the receiver returns to idle hunting.
- R2: Each data bit takes the majority value of its samples 8, 9 and 10. Bits are received least significant first, so the first data bit lands in `rx_data[0]`.
- R3: With `nine_bit` = 0 a character has 8 data bits and `rx_bit9` is loaded with 0. With `nine_bit` = 1 it has 9 data bits, and the ninth one is loaded into `rx_bit9`.
- R4: The character is transferred on the clock edge of the tick that carries sample 10 of the stop bit. `rx_ready` is high from that edge on. The receiver is back in idle hunting at that same edge.
- R5: `frame_err` is loaded with 1 when at least two of the stop bit's samples 8 to 10 are low, and with 0 otherwise. The character is delivered either way. The flag is replaced only by the next accepted transfer.
- R6: A cycle with `rd_strobe` high clears `rx_ready` at its clock edge, unless a transfer happens in the same cycle.
- R7: A character that completes while `rx_ready` is high and no read is in progress is discarded. `rx_data`, `rx_bit9` and `frame_err` keep the held character, and an overrun is recorded as pending. `overrun` changes only on a read, where it takes the pending value, and the pending value is then cleared.
- R8: While `rx_en` is low, the bit sequencer and the sample counter are held in idle, so a partly received character is abandoned. The holding register, `rx_ready` and the overrun state are kept.
- R9: After reset, `rx_data` = 0, `rx_bit9` = 0, `rx_ready` = 0, `frame_err` = 0 and `overrun` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| smp_tick | input | 1 | Sample strobe, one cycle wide, at 16x the bit rate |
| rx_in | input | 1 | Serial line, already synchronous to clk |
| nine_bit | input | 1 | 1 selects 9 data bits per character, 0 selects 8 |
| rd_strobe | input | 1 | Read of the holding register |
| rx_data | output | 8 | Received data bits 0 to 7 |
| rx_bit9 | output | 1 | Ninth received data bit |
| rx_ready | output | 1 | A received character is waiting |
| frame_err | output | 1 | The held character had a bad stop bit |
| overrun | output | 1 | A character was lost before the last read |

## Verification
There is no register between the stop-bit vote and the holding register. `rx_data`, `rx_bit9`, `frame_err` and `rx_ready` therefore change at the very clock edge that carries the tick with stop sample 10. The bench reads them at the following falling edge, so one result is due per character. `rx_ready` and `overrun` respond to a read at the edge that takes `rd_strobe`, and the bench checks them half a cycle later. A driver task computes each expected character from the samples it puts on the line and queues it. A monitor process pops the queue on each rising `rx_ready` and compares. The scenarios cover rejected start pulses, flipped mid-bit samples, the overrun flag being held back until a read, and a character abandoned by disabling the receiver. For each of these, the bench waits long enough that a wrong result would have shown up in `rx_ready` or `overrun`.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       bit9;
        logic       ferr;
    } rx_char_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
    parameter int unsigned OSR = 16,
    parameter int unsigned MID = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic hunt,
    input  logic tick,
    input  logic rx,
    output logic vote_stb,
    output logic vote_val
);
    import uart_rx_pkg::*;

    localparam int unsigned CW = $clog2(OSR + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] nxt;
    logic [1:0]    early;

    assign nxt = (cnt == CW'(OSR)) ? CW'(1) : cnt + CW'(1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt   <= '0;
            early <= '0;
        end else if (hunt) begin
            cnt <= (tick && !rx) ? CW'(1) : '0;
        end else if (tick) begin
            cnt <= nxt;
            if (nxt == CW'(MID))     early[0] <= rx;
            if (nxt == CW'(MID + 1)) early[1] <= rx;
        end
    end

    assign vote_stb = en && !hunt && tick && (nxt == CW'(MID + 2));
    assign vote_val = vote3(early[0], early[1], rx);

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  tick,
    input  logic                  rx,
    input  logic                  nine,
    input  logic                  vote_stb,
    input  logic                  vote_val,
    output logic                  hunt,
    output logic                  load,
    output uart_rx_pkg::rx_char_t load_char
);
    import uart_rx_pkg::*;

    rx_state_e  state;
    logic [3:0] bidx;
    logic [8:0] sh;
    logic [3:0] last;

    assign last = nine ? 4'd8 : 4'd7;
    assign hunt = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= ST_IDLE;
            bidx  <= '0;
        end else begin
            case (state)
                ST_IDLE:  if (tick && !rx) state <= ST_START;
                ST_START: if (vote_stb) begin
                    bidx  <= '0;
                    state <= vote_val ? ST_IDLE : ST_DATA;
                end
                ST_DATA:  if (vote_stb) begin
                    bidx <= bidx + 4'd1;
                    if (bidx == last) state <= ST_STOP;
                end
                ST_STOP:  if (vote_stb) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (en && state == ST_DATA && vote_stb) begin
            sh <= {vote_val, sh[8:1]};
        end
    end

    assign load = (state == ST_STOP) && vote_stb;

    always_comb begin
        load_char.data = nine ? sh[7:0] : sh[8:1];
        load_char.bit9 = nine ? sh[8] : 1'b0;
        load_char.ferr = !vote_val;
    end

    assert_disable_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state == ST_IDLE));

    assert_start_reject_R1: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_START && vote_stb && vote_val) |=> (state == ST_IDLE));

    assert_stop_to_idle_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (state == ST_IDLE));

endmodule

// File: rtl/uart_rx_holder.sv
module uart_rx_holder (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  uart_rx_pkg::rx_char_t load_char,
    input  logic                  rd,
    output uart_rx_pkg::rx_char_t held,
    output logic                  ready,
    output logic                  ovr_vis
);
    import uart_rx_pkg::*;

    logic ovr_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            held     <= '0;
            ready    <= 1'b0;
            ovr_vis  <= 1'b0;
            ovr_pend <= 1'b0;
        end else begin
            if (rd) begin
                ready    <= 1'b0;
                ovr_vis  <= ovr_pend;
                ovr_pend <= 1'b0;
            end
            if (load) begin
                if (ready && !rd) begin
                    ovr_pend <= 1'b1;
                end else begin
                    held  <= load_char;
                    ready <= 1'b1;
                end
            end
        end
    end

    assert_ready_on_load_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> ready);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (rd && !load) |=> !ready);

    assert_lost_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (load && ready && !rd) |=> $stable(held));

    assert_ovr_on_read_R7: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(ovr_vis));

endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
    parameter int unsigned OSR = 16,
    parameter int unsigned MID = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  logic       smp_tick,
    input  logic       rx_in,
    input  logic       nine_bit,
    input  logic       rd_strobe,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       rx_ready,
    output logic       frame_err,
    output logic       overrun
);
    import uart_rx_pkg::*;

    logic     hunt;
    logic     vote_stb;
    logic     vote_val;
    logic     load;
    rx_char_t load_char;
    rx_char_t held;

    uart_rx_sampler #(.OSR(OSR), .MID(MID)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .en       (rx_en),
        .hunt     (hunt),
        .tick     (smp_tick),
        .rx       (rx_in),
        .vote_stb (vote_stb),
        .vote_val (vote_val)
    );

    uart_rx_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .en        (rx_en),
        .tick      (smp_tick),
        .rx        (rx_in),
        .nine      (nine_bit),
        .vote_stb  (vote_stb),
        .vote_val  (vote_val),
        .hunt      (hunt),
        .load      (load),
        .load_char (load_char)
    );

    uart_rx_holder u_holder (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_char (load_char),
        .rd        (rd_strobe),
        .held      (held),
        .ready     (rx_ready),
        .ovr_vis   (overrun)
    );

    assign rx_data   = held.data;
    assign rx_bit9   = held.bit9;
    assign frame_err = held.ferr;

endmodule

// File: tb/test_uart_rx_vote.sv
`timescale 1ns/1ps
module test_uart_rx_vote;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_en = 1'b0;
    logic smp_tick = 1'b0;
    logic rx_in = 1'b1;
    logic nine_bit = 1'b0;
    logic mon_rd = 1'b0;
    logic man_rd = 1'b0;
    logic rd_strobe;
    logic [7:0] rx_data;
    logic rx_bit9, rx_ready, frame_err, overrun;

    int checks = 0;
    int fails = 0;
    int pops = 0;
    bit auto_read = 1'b0;
    bit done = 1'b0;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    assign rd_strobe = mon_rd | man_rd;

    always #2.5 clk = ~clk;

    uart_rx_vote i_uart_rx_vote (
        .clk(clk), .rst(rst), .rx_en(rx_en), .smp_tick(smp_tick), .rx_in(rx_in),
        .nine_bit(nine_bit), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_ready(rx_ready), .frame_err(frame_err), .overrun(overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each waiting character
    always @(negedge clk) begin
        if (auto_read && rx_ready && !mon_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R4: actual unexpected char %0h expected none",
                         {rx_data, rx_bit9, frame_err});
            end else begin
                logic [9:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({rx_data, rx_bit9, frame_err} !== e) begin
                    fails++;
                    $display("FAIL %s: actual %0h expected %0h", t,
                             {rx_data, rx_bit9, frame_err}, e);
                end
            end
            pops++;
            mon_rd <= 1'b1;
        end else begin
            mon_rd <= 1'b0;
        end
    end

    task automatic tick_once(input logic v);
        @(negedge clk);
        rx_in = v;
        smp_tick = 1'b1;
        @(negedge clk);
        smp_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // driver: sends one frame, gbit/gmask invert chosen ticks of one bit period
    task automatic send_char(input logic [8:0] d, input int gbit, input logic [15:0] gmask,
                             input bit push, input string tag);
        int nb;
        int total;
        logic [10:0] obs;
        nb = nine_bit ? 9 : 8;
        total = nb + 2;
        obs = '0;
        for (int b = 0; b < total; b++) begin
            logic base;
            int flips;
            base = (b == 0) ? 1'b0 : (b == total - 1) ? 1'b1 : d[b-1];
            flips = (b == gbit) ? (int'(gmask[7]) + int'(gmask[8]) + int'(gmask[9])) : 0;
            obs[b] = base ^ (flips >= 2);
        end
        if (push) begin
            logic [7:0] ed;
            logic eb9;
            ed = obs[8:1];
            eb9 = nine_bit ? obs[9] : 1'b0;
            exp_q.push_back({ed, eb9, ~obs[total-1]});
            tag_q.push_back(tag);
        end
        for (int b = 0; b < total; b++) begin
            logic base;
            base = (b == 0) ? 1'b0 : (b == total - 1) ? 1'b1 : d[b-1];
            for (int k = 1; k <= 16; k++)
                tick_once(base ^ ((b == gbit) && gmask[k-1]));
        end
        repeat (3) tick_once(1'b1);
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        check("R4 drain", exp_q.size(), 0);
    endtask

    task automatic manual_read();
        @(negedge clk);
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 data", rx_data, 0);
        check("R9 flags", {rx_bit9, rx_ready, frame_err, overrun}, 0);
        rx_en = 1'b1;
        auto_read = 1'b1;
        repeat (2) tick_once(1'b1);

        // R2 plain and with voted-away glitches
        send_char(9'h0A5, -1, 16'h0, 1'b1, "R2 plain");
        send_char(9'h03C, 3, 16'h0100, 1'b1, "R2 single flip");
        send_char(9'h03C, 5, 16'h0180, 1'b1, "R2 double flip");
        send_char(9'h0C3, 1, 16'h0380, 1'b1, "R2 triple flip");
        wait_drain();

        // R3 nine-bit mode
        nine_bit = 1'b1;
        send_char(9'h15A, -1, 16'h0, 1'b1, "R3 ninth one");
        send_char(9'h0FF, -1, 16'h0, 1'b1, "R3 ninth zero");
        nine_bit = 1'b0;
        send_char(9'h166, -1, 16'h0, 1'b1, "R3 eight-bit");
        wait_drain();

        // R5 bad stop delivered, then replaced
        send_char(9'h081, 9, 16'h0180, 1'b1, "R5 bad stop");
        send_char(9'h042, 9, 16'h0100, 1'b1, "R5 stop single low");
        wait_drain();

        // R1 start glitch of 8 low samples: rejected
        begin
            int p0;
            p0 = pops;
            repeat (8) tick_once(1'b0);
            repeat (200) tick_once(1'b1);
            check("R1 reject ready", rx_ready, 0);
            check("R1 reject pops", pops - p0, 0);
        end
        // R1 9 low samples: accepted start, line high after
        exp_q.push_back({8'hFF, 1'b0, 1'b0});
        tag_q.push_back("R1 accept");
        repeat (9) tick_once(1'b0);
        repeat (170) tick_once(1'b1);
        wait_drain();

        // R7 overrun, buffered until read
        auto_read = 1'b0;
        send_char(9'h011, -1, 16'h0, 1'b0, "");
        check("R4 ready", rx_ready, 1);
        check("R4 data", rx_data, 8'h11);
        send_char(9'h022, 9, 16'h0380, 1'b0, "");
        check("R7 held data", rx_data, 8'h11);
        check("R7 held ferr", frame_err, 0);
        check("R7 not yet visible", overrun, 0);
        manual_read();
        check("R7 visible after read", overrun, 1);
        check("R6 ready cleared", rx_ready, 0);
        send_char(9'h033, -1, 16'h0, 1'b0, "");
        check("R7 new data", rx_data, 8'h33);
        manual_read();
        check("R7 cleared on read", overrun, 0);

        // R8 disable abandons partial char, keeps holding register
        send_char(9'h055, -1, 16'h0, 1'b0, "");
        repeat (40) tick_once(1'b0);
        @(negedge clk);
        rx_en = 1'b0;
        repeat (5) tick_once(1'b1);
        rx_en = 1'b1;
        repeat (200) tick_once(1'b1);
        check("R8 ready kept", rx_ready, 1);
        check("R8 data kept", rx_data, 8'h55);
        manual_read();
        check("R8 no overrun", overrun, 0);
        check("R8 ready read", rx_ready, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule